// File: doc/BRIEF.md
# Periodic Interval Timer

A 32-bit down-counting timer with a word-addressed register port and a single level-sensitive interrupt. Software writes a reload value, then issues start or stop commands through a control word. The counter either halts at the first expiry (one-shot) or reloads itself from the stored period and keeps going (continuous). The live count can be read at any time through a read-only snapshot slot.

Each expiry sets a sticky timeout flag. Any write to the status slot clears that flag. The interrupt line is the flag gated by an enable bit in the control word. Bus transactions complete in one cycle: a write takes effect at the clock edge that ends its cycle, and read data is presented combinationally during the read cycle.

Top module: `interval_timer`

## Requirements
- R1: The word slot is byte address bits [ADDR_W-1:2]. Slot 0 is status, 1 is control, 2 is period and 3 is snapshot. Address bits [1:0] are ignored. A read from any slot at or above 4 returns zero, and `bus_rdata` is zero when no read is in progress.
- R2: After reset every slot reads zero, `irq` is low and the counter is stopped.
- R3: Any write to slot 0 clears the timeout flag (status bit 0), whatever data is written.
- R4: A write to slot 2 stores the period. It also loads that value into the counter at the same edge, even while the counter is running, and the snapshot shows the new value in the next cycle.
- R5: A control write with bit 2 set starts counting. While running, the count drops by one every clock, and status bit 1 reads 1.
- R6: A control write with bit 3 set stops counting and the count holds. When bits 2 and 3 are both set in one write, the counter stops.
- R7: A running count expires in the cycle where it is 1 or 0, so a start from zero expires in its first running cycle. In one-shot mode (control bit 1 = 0), expiry sets the timeout flag, leaves the count at 0 and stops the counter.
- R8: In continuous mode (control bit 1 = 1), expiry sets the timeout flag, reloads the count from the period and keeps running. With period P, expiries come every P clocks.
- R9: `irq` is high exactly while the timeout flag and control bit 0 are both set. It follows the registers from the cycle after any write or expiry.
- R10: Writes to the snapshot slot or to unmapped slots change no register and no count.
- R11: When an expiry and a status write fall in the same cycle, the timeout flag ends up set.
- R12: A control write stores all 32 bits, and reading slot 1 returns them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | W | Write data |
| bus_rdata | output | W | Read data, valid during the read cycle |
| irq | output | 1 | Level interrupt |

## Verification
Two functions can land on the same clock edge: an expiry that sets the timeout flag, and a status write that clears it. The bench runs the counter in continuous mode with a period of four and places a status write in the exact cycle whose edge produces the second expiry. It then judges the outcome by reading status in the next cycle, where both the flag and the running bit must read 1. A status write one cycle later, away from any expiry, must clear the flag, which shows that the first clear was overridden rather than ignored. A period write that meets a running decrement is checked in the same way through the snapshot value.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        SLOT_STAT   = 2'd0,
        SLOT_CTRL   = 2'd1,
        SLOT_PERIOD = 2'd2,
        SLOT_SNAP   = 2'd3
    } slot_e;

    localparam int NUM_SLOTS = 4;

    localparam int CTL_IEN  = 0;
    localparam int CTL_CONT = 1;
    localparam int CTL_GO   = 2;
    localparam int CTL_HALT = 3;

    localparam int ST_TO  = 0;
    localparam int ST_RUN = 1;

    typedef struct packed {
        logic stat;
        logic ctrl;
        logic period;
    } wr_strobe_t;

    typedef struct packed {
        logic go;
        logic halt;
    } run_cmd_t;

    function automatic run_cmd_t cmd_from_word(input logic [3:0] low);
        run_cmd_t c;
        c.go   = low[CTL_GO];
        c.halt = low[CTL_HALT];
        return c;
    endfunction

endpackage

// File: rtl/tmr_bus_decode.sv
module tmr_bus_decode
    import tmr_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              sel,
    input  logic              we,
    input  logic [ADDR_W-3:0] word,
    output wr_strobe_t        wr,
    output logic              rd_hit,
    output slot_e             slot
);
    localparam int WORD_W = ADDR_W - 2;

    logic mapped;

    generate
        if (WORD_W > 2) begin : g_wide
            assign mapped = (word[WORD_W-1:2] == '0);
        end else begin : g_narrow
            assign mapped = 1'b1;
        end
    endgenerate

    assign slot = slot_e'(word[1:0]);

    always_comb begin
        wr        = '0;
        wr.stat   = sel && we && mapped && (slot == SLOT_STAT);
        wr.ctrl   = sel && we && mapped && (slot == SLOT_CTRL);
        wr.period = sel && we && mapped && (slot == SLOT_PERIOD);
        rd_hit    = sel && !we && mapped;
    end

endmodule

// File: rtl/tmr_downcounter.sv
module tmr_downcounter
    import tmr_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         cmd_wr,
    input  run_cmd_t     cmd,
    input  logic         cont,
    input  logic [W-1:0] period,
    output logic [W-1:0] cnt,
    output logic         run,
    output logic         expire
);
    logic [W-1:0] cnt_d;
    logic         run_d;

    assign expire = run && ((cnt == '0) || (cnt == W'(1)));

    always_comb begin
        cnt_d = cnt;
        run_d = run;
        if (run) begin
            if (expire) begin
                cnt_d = cont ? period : '0;
                run_d = cont;
            end else begin
                cnt_d = cnt - W'(1);
            end
        end
        if (load) begin
            cnt_d = load_val;
        end
        if (cmd_wr) begin
            if (cmd.halt) begin
                run_d = 1'b0;
            end else if (cmd.go) begin
                run_d = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            run <= 1'b0;
        end else begin
            cnt <= cnt_d;
            run <= run_d;
        end
    end

endmodule

// File: rtl/tmr_flag_irq.sv
module tmr_flag_irq (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    input  logic ien,
    output logic to_flag,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            to_flag <= 1'b0;
        end else if (set) begin
            to_flag <= 1'b1;
        end else if (clr) begin
            to_flag <= 1'b0;
        end
    end

    assign irq = to_flag && ien;

endmodule

// File: rtl/interval_timer.sv
module interval_timer
    import tmr_pkg::*;
#(
    parameter int W      = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    output logic              irq
);
    wr_strobe_t   wr;
    logic         rd_hit;
    slot_e        slot;
    logic [W-1:0] ctrl_q;
    logic [W-1:0] period_q;
    logic [W-1:0] cnt;
    logic         run;
    logic         expire;
    logic         to_flag;
    logic [1:0]   addr_lane_unused;

    assign addr_lane_unused = bus_addr[1:0];

    tmr_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
        .sel    (bus_sel),
        .we     (bus_we),
        .word   (bus_addr[ADDR_W-1:2]),
        .wr     (wr),
        .rd_hit (rd_hit),
        .slot   (slot)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            period_q <= '0;
        end else begin
            if (wr.ctrl)   ctrl_q   <= bus_wdata;
            if (wr.period) period_q <= bus_wdata;
        end
    end

    tmr_downcounter #(.W(W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (wr.period),
        .load_val (bus_wdata),
        .cmd_wr   (wr.ctrl),
        .cmd      (cmd_from_word(bus_wdata[3:0])),
        .cont     (ctrl_q[CTL_CONT]),
        .period   (period_q),
        .cnt      (cnt),
        .run      (run),
        .expire   (expire)
    );

    tmr_flag_irq u_flag (
        .clk     (clk),
        .rst     (rst),
        .set     (expire),
        .clr     (wr.stat),
        .ien     (ctrl_q[CTL_IEN]),
        .to_flag (to_flag),
        .irq     (irq)
    );

    always_comb begin
        bus_rdata = '0;
        if (rd_hit) begin
            unique case (slot)
                SLOT_STAT: begin
                    bus_rdata[ST_TO]  = to_flag;
                    bus_rdata[ST_RUN] = run;
                end
                SLOT_CTRL:   bus_rdata = ctrl_q;
                SLOT_PERIOD: bus_rdata = period_q;
                SLOT_SNAP:   bus_rdata = cnt;
                default:     bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/interval_timer_chk.sv
module interval_timer_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst,
    input logic         stat_wr,
    input logic         ctrl_wr,
    input logic         period_wr,
    input logic [W-1:0] wdata,
    input logic [W-1:0] period,
    input logic [W-1:0] cnt,
    input logic         run,
    input logic         expire,
    input logic         to_flag,
    input logic         cont,
    input logic         ien,
    input logic         irq
);
    p_clear_r3: assert property (@(posedge clk) disable iff (rst)
        stat_wr && !expire |=> !to_flag);

    p_set_wins_r11: assert property (@(posedge clk) disable iff (rst)
        expire |=> to_flag);

    p_load_r4: assert property (@(posedge clk) disable iff (rst)
        period_wr |=> cnt == $past(wdata));

    p_step_r5: assert property (@(posedge clk) disable iff (rst)
        run && !expire && !period_wr |=> cnt == $past(cnt) - W'(1));

    p_stop_wins_r6: assert property (@(posedge clk) disable iff (rst)
        ctrl_wr && wdata[3] |=> !run);

    p_oneshot_r7: assert property (@(posedge clk) disable iff (rst)
        expire && !cont && !ctrl_wr && !period_wr |=> !run && cnt == '0);

    p_reload_r8: assert property (@(posedge clk) disable iff (rst)
        expire && cont && !ctrl_wr && !period_wr |=> run && cnt == $past(period));

    p_irq_r9: assert property (@(posedge clk) disable iff (rst)
        expire && ien && !ctrl_wr |=> irq);

endmodule

bind interval_timer interval_timer_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .stat_wr   (wr.stat),
    .ctrl_wr   (wr.ctrl),
    .period_wr (wr.period),
    .wdata     (bus_wdata),
    .period    (period_q),
    .cnt       (cnt),
    .run       (run),
    .expire    (expire),
    .to_flag   (to_flag),
    .cont      (ctrl_q[1]),
    .ien       (ctrl_q[0]),
    .irq       (irq)
);

// File: tb/interval_timer_bench.sv
module interval_timer_bench;
    localparam int W      = 32;
    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] A_STAT   = 5'h00;
    localparam logic [ADDR_W-1:0] A_CTRL   = 5'h04;
    localparam logic [ADDR_W-1:0] A_PERIOD = 5'h08;
    localparam logic [ADDR_W-1:0] A_SNAP   = 5'h0C;

    typedef struct {
        string       tag;
        logic [31:0] exp;
        bit          is_irq;
    } item_t;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_sel = 1'b0;
    logic              bus_we = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [W-1:0]      bus_wdata = '0;
    logic [W-1:0]      bus_rdata;
    logic              irq;
    logic              chk_irq = 1'b0;
    bit                done = 1'b0;

    int checks = 0;
    int failures = 0;
    item_t sb[$];

    always #5 clk = ~clk;

    interval_timer #(.W(W), .ADDR_W(ADDR_W)) u_interval_timer (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    task automatic step();
        @(posedge clk);
        #1;
        bus_sel = 1'b0;
        bus_we  = 1'b0;
        chk_irq = 1'b0;
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        step();
        bus_sel   = 1'b1;
        bus_we    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, input logic [31:0] e, input string tag);
        item_t it;
        step();
        it.tag = tag; it.exp = e; it.is_irq = 1'b0;
        sb.push_back(it);
        bus_sel  = 1'b1;
        bus_we   = 1'b0;
        bus_addr = a;
    endtask

    task automatic expect_irq(input logic e, input string tag);
        item_t it;
        step();
        it.tag = tag; it.exp = {31'd0, e}; it.is_irq = 1'b1;
        sb.push_back(it);
        chk_irq = 1'b1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    // monitor: samples mid-cycle and compares against the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if ((bus_sel && !bus_we) || chk_irq) begin
                item_t it;
                logic [31:0] act;
                if (sb.size() == 0) begin
                    failures++;
                    $display("FAIL monitor: result with empty queue");
                end else begin
                    it = sb.pop_front();
                    act = it.is_irq ? {31'd0, irq} : bus_rdata;
                    checks++;
                    if (act !== it.exp) begin
                        failures++;
                        $display("FAIL %s: actual=0x%08h expected=0x%08h", it.tag, act, it.exp);
                    end
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst = 1'b0;
        // R2 reset state
        rd(A_STAT, 0, "R2 status");
        rd(A_CTRL, 0, "R2 control");
        rd(A_PERIOD, 0, "R2 period");
        rd(A_SNAP, 0, "R2 snapshot");
        expect_irq(1'b0, "R2 irq");
        // R4 period load, R1 decode
        wr(A_PERIOD, 100);
        rd(A_PERIOD, 100, "R4 period");
        rd(A_SNAP, 100, "R4 snapshot");
        rd(5'h0B, 100, "R1 lane bits ignored");
        rd(5'h14, 0, "R1 unmapped read");
        // R10 ignored writes
        wr(A_SNAP, 55);
        rd(A_SNAP, 100, "R10 snapshot write");
        wr(5'h18, 32'hFFFF);
        rd(A_PERIOD, 100, "R10 unmapped period");
        rd(A_CTRL, 0, "R10 unmapped control");
        // R12 / R5 start and count
        wr(A_CTRL, 32'hF4);
        rd(A_CTRL, 32'hF4, "R12 control word");
        rd(A_SNAP, 99, "R5 first step");
        idle(3);
        rd(A_SNAP, 95, "R5 count");
        rd(A_STAT, 2, "R5 running bit");
        // R6 stop
        wr(A_CTRL, 32'h8);
        rd(A_SNAP, 92, "R6 stopped count");
        idle(2);
        rd(A_SNAP, 92, "R6 count holds");
        wr(A_CTRL, 32'hC);
        rd(A_STAT, 0, "R6 both bits stop");
        idle(2);
        rd(A_SNAP, 92, "R6 both bits hold");
        // R7 one-shot expiry, R9 irq
        wr(A_PERIOD, 3);
        wr(A_CTRL, 32'h5);
        expect_irq(1'b0, "R9 before expiry");
        idle(2);
        rd(A_STAT, 1, "R7 one-shot stopped with flag");
        rd(A_SNAP, 0, "R7 count at zero");
        expect_irq(1'b1, "R9 irq asserted");
        wr(A_CTRL, 32'h0);
        expect_irq(1'b0, "R9 enable off");
        rd(A_STAT, 1, "R9 flag kept");
        wr(A_CTRL, 32'h1);
        expect_irq(1'b1, "R9 enable on");
        wr(A_STAT, 32'h0);
        rd(A_STAT, 0, "R3 clear with zero data");
        expect_irq(1'b0, "R9 irq after clear");
        // R8 continuous, R11 collision
        wr(A_PERIOD, 4);
        wr(A_CTRL, 32'h6);
        idle(3);
        rd(A_SNAP, 1, "R8 before expiry");
        rd(A_STAT, 3, "R8 flag and running");
        rd(A_SNAP, 3, "R8 reloaded");
        expect_irq(1'b0, "R9 gated by enable");
        wr(A_STAT, 32'hFFFF_FFFF);
        rd(A_STAT, 3, "R11 expiry beats clear");
        wr(A_STAT, 32'h5A);
        rd(A_STAT, 2, "R3 clear while running");
        wr(A_CTRL, 32'h8);
        // R7 zero start
        wr(A_PERIOD, 0);
        wr(A_CTRL, 32'h4);
        idle(1);
        rd(A_STAT, 1, "R7 zero start expires");
        rd(A_SNAP, 0, "R7 zero count");
        // R4 load while running
        wr(A_PERIOD, 50);
        wr(A_CTRL, 32'h4);
        idle(1);
        wr(A_PERIOD, 10);
        rd(A_SNAP, 10, "R4 load while running");
        rd(A_SNAP, 9, "R4 keeps counting");
        wr(A_CTRL, 32'h8);
        idle(4);
        done = 1'b1;
        if (sb.size() != 0) begin
            failures++;
            $display("FAIL scoreboard: actual=%0d pending expected=0", sb.size());
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule